// File: doc/BRIEF.md
# Destination Address Match Filter

This block decides whether an incoming frame is addressed to this station. It keeps a table of sixteen 48-bit station addresses. Each one takes part in matching only while its bit in a 16-bit enable mask is set. A compare strobe presents a destination address. One clock later the block returns a registered result with a valid pulse. The result says whether the frame is accepted, whether it hit as broadcast, whether it hit the table, and which entry matched.

Entries are written through a load port that carries an index and a full 48-bit address. Host software can inspect the table in 16-bit slices. An entry pointer picks the entry and a slice select picks the pair of bytes. These reads return real data only while the surrounding controller holds its reset flag. At any other time they return zero, so the table cannot be observed during operation.

Top module: `dest_addr_filter`

## Requirements
- R1: After reset every table entry reads as zero. Asserting `load_we` writes `load_addr` into entry `load_idx` on that clock edge.
- R2: `res_valid` goes high for exactly one cycle, on the clock edge after a cycle in which `cmp_strobe` is high. It stays low after any cycle without a strobe.
- R3: An entry whose bit in `entry_en` is clear never produces a table hit, even when its address is equal to the destination.
- R4: When `bcast_en` is 1 and the destination is all ones, the result has `res_accept`=1, `res_bcast`=1, `res_hit`=0 and `res_index`=0. The table is not consulted.
- R5: When `bcast_en` is 0, an all-ones destination is treated like any other address. It is accepted only through an enabled entry that matches it.
- R6: A table hit requires all 48 bits to be equal. A difference in any single byte, including the lowest or the highest, gives no hit.
- R7: When several enabled entries match, `res_index` reports the lowest-numbered one.
- R8: A result with neither a broadcast hit nor a table hit has `res_accept`=0, `res_hit`=0 and `res_index`=0.
- R9: Byte k of an address occupies bits [8k+7:8k]. With reads permitted, `rd_data` is built as follows. The entry is selected by `entry_ptr[3:0]`, and all higher pointer bits are ignored. For a slice select p of 0, 1 or 2, the read returns byte 2p+1 in the upper half and byte 2p in the lower half. A slice select of 3 returns zero.
- R10: `rd_data` is zero whenever `ctrl_in_reset` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_in_reset | input | 1 | Controller reset flag; table reads are allowed only while this is 1 |
| bcast_en | input | 1 | Accept all-ones destinations as broadcast |
| entry_en | input | 16 | Per-entry match enable mask |
| load_we | input | 1 | Write strobe for a table entry |
| load_idx | input | 4 | Entry index to write |
| load_addr | input | 48 | Address value to write |
| entry_ptr | input | 16 | Entry pointer for host reads; only the low 4 bits are used |
| rd_sel | input | 2 | Slice select for host reads |
| rd_data | output | 16 | Host read data |
| cmp_strobe | input | 1 | Start a compare of `cmp_addr` |
| cmp_addr | input | 48 | Destination address to classify |
| res_valid | output | 1 | Result valid pulse |
| res_accept | output | 1 | Frame accepted |
| res_bcast | output | 1 | Accepted as broadcast |
| res_hit | output | 1 | Accepted through the table |
| res_index | output | 4 | Lowest matching entry, or 0 |

## Verification
The bench builds the block with its default parameters: 16 entries, 48-bit addresses, 16-bit slices and a 16-bit pointer. This makes the top entry, index 15, reachable both for matching and for host reads. It also lets the bench drive pointer values whose upper bits are set, which shows that those bits are ignored. The same address is stored in entries 5 and 9, so that the priority order and per-entry masking can be seen directly. Entry 15 holds all ones, which sets the broadcast path against a genuine table match.

// File: rtl/addr_filt_pkg.sv
// Shared definitions for the destination address filter.
// Assumes byte k of an address occupies bits [8k+7:8k].
package addr_filt_pkg;

    localparam int BYTE_W = 8;

    // Registered classification flags of one compare.
    typedef struct packed {
        logic accept;
        logic bcast;
        logic hit;
    } filt_flags_t;

endpackage

// File: rtl/cam_table.sv
// Storage for the station address table.
// Holds NUM_ENTRIES addresses of ADDR_W bits. One entry is written per clock
// through the load port. The whole table is exposed flat for the compare
// logic and the read logic. Assumes load_idx is below NUM_ENTRIES.
module cam_table #(
    parameter int NUM_ENTRIES = 16,
    parameter int ADDR_W      = 48,
    localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load_we,
    input  logic [IDX_W-1:0]              load_idx,
    input  logic [ADDR_W-1:0]             load_addr,
    output logic [NUM_ENTRIES*ADDR_W-1:0] tbl_flat
);

    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_entry
        logic [ADDR_W-1:0] entry_q;

        // Clear on reset, capture the load data when this entry is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)
                entry_q <= '0;
            else if (load_we && (load_idx == IDX_W'(e)))
                entry_q <= load_addr;
        end

        assign tbl_flat[e*ADDR_W +: ADDR_W] = entry_q;
    end

    AST_LOAD_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        load_we |=> tbl_flat[$past(load_idx)*ADDR_W +: ADDR_W] == $past(load_addr)); // R1

endmodule

// File: rtl/match_unit.sv
// Combinational classifier for one destination address.
// The broadcast check takes precedence over the table. A table entry counts
// only when its enable bit is set, and the lowest matching index wins.
module match_unit
    import addr_filt_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int ADDR_W      = 48,
    localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
    input  logic [NUM_ENTRIES*ADDR_W-1:0] tbl_flat,
    input  logic [NUM_ENTRIES-1:0]        entry_en,
    input  logic                          bcast_en,
    input  logic [ADDR_W-1:0]             dest,
    output filt_flags_t                   flags,
    output logic [IDX_W-1:0]              index
);

    logic [NUM_ENTRIES-1:0] eq_vec;
    logic                   is_bcast;

    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_cmp
        assign eq_vec[e] = entry_en[e] && (tbl_flat[e*ADDR_W +: ADDR_W] == dest);
    end

    assign is_bcast = bcast_en && (&dest);

    // Pick the lowest matching entry unless broadcast already decided.
    always_comb begin
        flags = '0;
        index = '0;
        if (is_bcast) begin
            flags.accept = 1'b1;
            flags.bcast  = 1'b1;
        end else begin
            for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
                if (eq_vec[i]) begin
                    flags.hit = 1'b1;
                    index     = IDX_W'(i);
                end
            end
            flags.accept = flags.hit;
        end
    end

endmodule

// File: rtl/table_read_mux.sv
// Host read path into the table.
// Selects an entry by index and a SLICE_W slice within it. Returns zero for
// slice selects beyond the entry, and whenever reads are not allowed.
module table_read_mux #(
    parameter int NUM_ENTRIES = 16,
    parameter int ADDR_W      = 48,
    parameter int SLICE_W     = 16,
    localparam int IDX_W      = $clog2(NUM_ENTRIES),
    localparam int NUM_SLICES = ADDR_W / SLICE_W,
    localparam int SEL_W      = $clog2(NUM_SLICES + 1)
) (
    input  logic [NUM_ENTRIES*ADDR_W-1:0] tbl_flat,
    input  logic [IDX_W-1:0]              rd_idx,
    input  logic [SEL_W-1:0]              rd_sel,
    input  logic                          rd_allow,
    output logic [SLICE_W-1:0]            rd_data
);

    logic [ADDR_W-1:0] entry_sel;

    assign entry_sel = tbl_flat[rd_idx*ADDR_W +: ADDR_W];

    // Gate the selected slice by the permission and the range of the select.
    always_comb begin
        rd_data = '0;
        for (int s = 0; s < NUM_SLICES; s++) begin
            if (rd_allow && (rd_sel == SEL_W'(s)))
                rd_data = entry_sel[s*SLICE_W +: SLICE_W];
        end
    end

endmodule

// File: rtl/dest_addr_filter.sv
// Destination address filter top.
// Classifies a destination on cmp_strobe and registers the result for one
// cycle with a valid pulse. Hosts the address table and its read path.
// Assumes entry_en and bcast_en are stable during the strobe cycle.
module dest_addr_filter
    import addr_filt_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int ADDR_W      = 48,
    parameter int SLICE_W     = 16,
    parameter int PTR_W       = 16,
    localparam int IDX_W      = $clog2(NUM_ENTRIES),
    localparam int SEL_W      = $clog2(ADDR_W / SLICE_W + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ctrl_in_reset,
    input  logic                   bcast_en,
    input  logic [NUM_ENTRIES-1:0] entry_en,
    input  logic                   load_we,
    input  logic [IDX_W-1:0]       load_idx,
    input  logic [ADDR_W-1:0]      load_addr,
    input  logic [PTR_W-1:0]       entry_ptr,
    input  logic [SEL_W-1:0]       rd_sel,
    output logic [SLICE_W-1:0]     rd_data,
    input  logic                   cmp_strobe,
    input  logic [ADDR_W-1:0]      cmp_addr,
    output logic                   res_valid,
    output logic                   res_accept,
    output logic                   res_bcast,
    output logic                   res_hit,
    output logic [IDX_W-1:0]       res_index
);

    logic [NUM_ENTRIES*ADDR_W-1:0] tbl_flat;
    filt_flags_t                   flags_d;
    filt_flags_t                   flags_q;
    logic [IDX_W-1:0]              index_d;
    logic [IDX_W-1:0]              index_q;
    logic                          valid_q;
    logic                          unused_ptr_hi;

    assign unused_ptr_hi = ^entry_ptr[PTR_W-1:IDX_W];

    cam_table #(.NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_we   (load_we),
        .load_idx  (load_idx),
        .load_addr (load_addr),
        .tbl_flat  (tbl_flat)
    );

    match_unit #(.NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W)) u_match (
        .tbl_flat (tbl_flat),
        .entry_en (entry_en),
        .bcast_en (bcast_en),
        .dest     (cmp_addr),
        .flags    (flags_d),
        .index    (index_d)
    );

    table_read_mux #(.NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W), .SLICE_W(SLICE_W)) u_rd (
        .tbl_flat (tbl_flat),
        .rd_idx   (entry_ptr[IDX_W-1:0]),
        .rd_sel   (rd_sel),
        .rd_allow (ctrl_in_reset),
        .rd_data  (rd_data)
    );

    // Register the classification; results are cleared when no strobe arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            flags_q <= '0;
            index_q <= '0;
        end else begin
            valid_q <= cmp_strobe;
            flags_q <= cmp_strobe ? flags_d : '0;
            index_q <= cmp_strobe ? index_d : '0;
        end
    end

    assign res_valid  = valid_q;
    assign res_accept = flags_q.accept;
    assign res_bcast  = flags_q.bcast;
    assign res_hit    = flags_q.hit;
    assign res_index  = index_q;

    AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_strobe |=> res_valid); // R2
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_strobe |=> !res_valid); // R2
    AST_BCAST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        res_bcast |-> (res_accept && !res_hit && res_valid)); // R4
    AST_BCAST_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        res_bcast |-> ($past(bcast_en) && (&$past(cmp_addr)))); // R4
    AST_ACCEPT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        res_accept |-> (res_valid && (res_hit || res_bcast))); // R8
    AST_READ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_in_reset |-> (rd_data == '0)); // R10

endmodule

// File: tb/dest_addr_filter_test.sv
module dest_addr_filter_test;

    localparam logic [47:0] E2   = 48'h6655_4433_2211;
    localparam logic [47:0] E5   = 48'h0C0B_0A09_0807;
    localparam logic [47:0] ONES = 48'hFFFF_FFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_in_reset = 1'b1;
    logic        bcast_en = 1'b0;
    logic [15:0] entry_en = '0;
    logic        load_we = 1'b0;
    logic [3:0]  load_idx = '0;
    logic [47:0] load_addr = '0;
    logic [15:0] entry_ptr = '0;
    logic [1:0]  rd_sel = '0;
    logic [15:0] rd_data;
    logic        cmp_strobe = 1'b0;
    logic [47:0] cmp_addr = '0;
    logic        res_valid, res_accept, res_bcast, res_hit;
    logic [3:0]  res_index;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    dest_addr_filter uut (
        .clk(clk), .rst_n(rst_n), .ctrl_in_reset(ctrl_in_reset),
        .bcast_en(bcast_en), .entry_en(entry_en),
        .load_we(load_we), .load_idx(load_idx), .load_addr(load_addr),
        .entry_ptr(entry_ptr), .rd_sel(rd_sel), .rd_data(rd_data),
        .cmp_strobe(cmp_strobe), .cmp_addr(cmp_addr),
        .res_valid(res_valid), .res_accept(res_accept), .res_bcast(res_bcast),
        .res_hit(res_hit), .res_index(res_index)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic load(input logic [3:0] idx, input logic [47:0] a);
        @(negedge clk);
        load_we = 1'b1; load_idx = idx; load_addr = a;
        @(negedge clk);
        load_we = 1'b0;
    endtask

    // Strobe one compare; on return the registered result is on the outputs.
    task automatic compare(input logic [47:0] a);
        @(negedge clk);
        cmp_strobe = 1'b1; cmp_addr = a;
        @(negedge clk);
        cmp_strobe = 1'b0;
    endtask

    // Packs {valid, accept, bcast, hit, index} for one comparison.
    function automatic logic [63:0] res();
        return {56'd0, res_valid, res_accept, res_bcast, res_hit, res_index};
    endfunction

    function automatic logic [63:0] exp_res(input logic acc, input logic bc,
                                            input logic hit, input logic [3:0] idx);
        return {56'd0, 1'b1, acc, bc, hit, idx};
    endfunction

    task automatic t_reset();
        check("R1 reset entry read", {48'd0, rd_data}, 64'd0);
        check("R2 reset valid", {63'd0, res_valid}, 64'd0);
        check("R8 reset accept", {63'd0, res_accept}, 64'd0);
    endtask

    task automatic t_readback();
        load(4'd2, E2); load(4'd5, E5); load(4'd9, E5); load(4'd15, ONES);
        ctrl_in_reset = 1'b1; entry_ptr = 16'd2;
        rd_sel = 2'd0; #1 check("R9 slice0", {48'd0, rd_data}, 64'h2211);
        rd_sel = 2'd1; #1 check("R9 slice1", {48'd0, rd_data}, 64'h4433);
        rd_sel = 2'd2; #1 check("R1 R9 slice2", {48'd0, rd_data}, 64'h6655);
        rd_sel = 2'd3; #1 check("R9 slice3 zero", {48'd0, rd_data}, 64'd0);
        entry_ptr = 16'hFFF5; rd_sel = 2'd2;
        #1 check("R9 pointer high bits ignored", {48'd0, rd_data}, 64'h0C0B);
        ctrl_in_reset = 1'b0; entry_ptr = 16'd2; rd_sel = 2'd0;
        #1 check("R10 read gated", {48'd0, rd_data}, 64'd0);
    endtask

    task automatic t_match();
        entry_en = 16'h8224;
        compare(E2);
        check("R2 R6 exact hit entry 2", res(), exp_res(1, 0, 1, 4'd2));
        @(negedge clk);
        check("R2 valid single cycle", {63'd0, res_valid}, 64'd0);
        compare(E5);
        check("R7 lowest index", res(), exp_res(1, 0, 1, 4'd5));
        entry_en = 16'h8204;
        compare(E5);
        check("R3 masked entry skipped", res(), exp_res(1, 0, 1, 4'd9));
        entry_en = 16'h8004;
        compare(E5);
        check("R3 R8 all matches masked", res(), exp_res(0, 0, 0, 4'd0));
        compare(E2 ^ 48'h1);
        check("R6 low byte differs", res(), exp_res(0, 0, 0, 4'd0));
        compare(E2 ^ (48'h1 << 47));
        check("R6 high byte differs", res(), exp_res(0, 0, 0, 4'd0));
        compare(48'h1234_5678_9ABC);
        check("R8 unknown address", res(), exp_res(0, 0, 0, 4'd0));
    endtask

    task automatic t_bcast();
        bcast_en = 1'b1;
        compare(ONES);
        check("R4 broadcast wins", res(), exp_res(1, 1, 0, 4'd0));
        bcast_en = 1'b0;
        compare(ONES);
        check("R5 all ones via table", res(), exp_res(1, 0, 1, 4'd15));
        entry_en = 16'h0004;
        compare(ONES);
        check("R5 all ones rejected", res(), exp_res(0, 0, 0, 4'd0));
    endtask

    initial begin
        #(200000 * 4);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_readback();
        t_match();
        t_bcast();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule